// File: doc/BRIEF.md
# Latched-Address One-Hot Decoder

This block turns a 3-bit binary address into eight active-high select lines, one of which is high when the block is enabled. An address hold stage sits in front of the decoder. While the hold control is low, the stage passes the live address through. When the hold control goes high, the stage keeps the address that was present at that moment, and later address changes do nothing until the hold control drops again.

Two output enables of opposite polarity gate the select lines. One is active low and one is active high. If either enable is inactive, every select line is low. The enables act only on the outputs. They never change the held address, so a held address comes back on the outputs as soon as the enables return, with no new hold cycle.

The implementation is fully synchronous. A system clock samples every input. The outputs are registered and show the result of the inputs sampled at the previous rising edge. The address is captured on the first clock edge at which the hold control is seen high.

Top module: `latdec_top`

## Requirements
- R1: While `rst_n_i` is low at a rising edge, `y_o` becomes all zero after that edge and the held address becomes 0.
- R2: With `hold_i` low, `en_low_n_i` low and `en_high_i` high at an edge, `y_o` after that edge has only bit n set, where n is the binary value of `addr_i` and `addr_i[0]` is the least significant bit (for example, `addr_i`=3'b101 sets only `y_o[5]`).
- R3: At the first edge where `hold_i` is sampled high after being low (or after reset), the address sampled at that edge is captured.
- R4: At later edges while `hold_i` stays high, `addr_i` has no effect: with the enables active, `y_o` keeps showing the captured address.
- R5: If `en_low_n_i` is high or `en_high_i` is low at an edge, `y_o` is all zero after that edge, whatever `hold_i` and `addr_i` are.
- R6: The enables never alter the held address. When the enables become active again while `hold_i` is still high, `y_o` shows the earlier captured address at the next edge.
- R7: At most one bit of `y_o` is ever high. Exactly one bit is high after any edge at which both enables were active.
- R8: After `hold_i` returns low, the outputs follow the live `addr_i` again from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n_i | input | 1 | Synchronous reset, active low |
| addr_i | input | 3 | Binary address, bit 0 least significant |
| hold_i | input | 1 | Address hold control: low = pass through, high = keep the captured address |
| en_low_n_i | input | 1 | Output enable, active low |
| en_high_i | input | 1 | Output enable, active high |
| y_o | output | 8 | One-hot select lines, active high |

## Verification
The bench changes the address while the hold is in effect. A design that kept tracking the input would move the selected line. The bench disables the outputs while holding, changes the address, and then re-enables the outputs. A design whose enables touched the hold register would come back with the wrong line, or with none. The bench also checks the first held edge directly. An off-by-one capture would keep the address from the cycle before or the cycle after. A sweep of all eight addresses catches a reversed bit order, which would swap lines such as 1 and 4. Random stimulus then mixes hold toggles and enable patterns against a bench model, and checks that no two lines are ever high together.

// File: rtl/latdec_pkg.sv
// latdec_pkg: shared types for the latched-address decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package latdec_pkg;

    // Output enable pair; the outputs are active only when en_low_n = 0 and en_high = 1
    typedef struct packed {
        logic en_low_n;
        logic en_high;
    } latdec_en_t;

    // True when the enable pair permits output
    function automatic logic latdec_enabled(input latdec_en_t en);
        return (!en.en_low_n) && en.en_high;
    endfunction

endpackage

// File: rtl/latdec_addr_hold.sv
// latdec_addr_hold: clocked address hold stage.
// While hold_i is low, the stage passes the live address through. On the first
// edge where hold_i is seen high, it captures the address sampled at that edge
// and keeps it while hold_i stays high.
// Assumes: hold_i and addr_i are synchronous to clk_i.
module latdec_addr_hold #(
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    output logic [ADDR_W-1:0] sel_o
);

    logic [ADDR_W-1:0] held_q;
    logic              hold_seen_q;
    logic              take_live;

    // Take the live address while passing through, or on the first held edge
    always_comb begin
        take_live = (!hold_i) || (!hold_seen_q);
        sel_o     = take_live ? addr_i : held_q;
    end

    // Store the selected address and remember the last sampled hold level
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            held_q      <= '0;
            hold_seen_q <= 1'b0;
        end else begin
            held_q      <= sel_o;
            hold_seen_q <= hold_i;
        end
    end

    // R3
    capture_first_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (hold_i && !hold_seen_q) |=> (held_q == $past(addr_i)));

    // R4
    held_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (hold_i && hold_seen_q) |=> $stable(held_q));

    // R8
    pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!hold_i) |=> (held_q == $past(addr_i)));

endmodule

// File: rtl/latdec_onehot.sv
// latdec_onehot: binary to one-hot decoder, bit 0 of sel_i least significant.
// Assumes: sel_i is a valid binary value; purely combinational.
module latdec_onehot #(
    parameter int ADDR_W = 3,
    parameter int OUT_N  = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] sel_i,
    output logic [OUT_N-1:0]  dec_o
);

    // One comparator per output line
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign dec_o[i] = (sel_i == ADDR_W'(i));
    end

endmodule

// File: rtl/latdec_out_stage.sv
// latdec_out_stage: registers the decoded lines, gated by the enable pair.
// Assumes: dec_i is one-hot; the enables touch only this stage.
module latdec_out_stage #(
    parameter int OUT_N = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_n_i,
    input  latdec_pkg::latdec_en_t en_i,
    input  logic [OUT_N-1:0]       dec_i,
    output logic [OUT_N-1:0]       y_o
);

    logic active;

    // Decide whether the lines may be driven this cycle
    always_comb begin
        active = latdec_pkg::latdec_enabled(en_i);
    end

    // Register the gated lines
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            y_o <= '0;
        end else begin
            y_o <= active ? dec_i : '0;
        end
    end

    // R7
    decode_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot(dec_i));

endmodule

// File: rtl/latdec_top.sv
// latdec_top: latched-address 3-to-8 one-hot decoder, clocked form.
// Inputs are sampled on the rising edge of clk_i; y_o reflects the previous edge.
// Assumes: all inputs are synchronous to clk_i; rst_n_i is synchronous, active low.
module latdec_top #(
    parameter int ADDR_W = 3,
    localparam int OUT_N = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    input  logic              en_low_n_i,
    input  logic              en_high_i,
    output logic [OUT_N-1:0]  y_o
);

    logic [ADDR_W-1:0]      sel;
    logic [OUT_N-1:0]       dec;
    latdec_pkg::latdec_en_t en;

    // Bundle the enable pins
    always_comb begin
        en.en_low_n = en_low_n_i;
        en.en_high  = en_high_i;
    end

    latdec_addr_hold #(.ADDR_W(ADDR_W)) hold_i_u (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .addr_i  (addr_i),
        .hold_i  (hold_i),
        .sel_o   (sel)
    );

    latdec_onehot #(.ADDR_W(ADDR_W), .OUT_N(OUT_N)) dec_u (
        .sel_i (sel),
        .dec_o (dec)
    );

    latdec_out_stage #(.OUT_N(OUT_N)) out_u (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .en_i    (en),
        .dec_i   (dec),
        .y_o     (y_o)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        (!rst_n_i) |=> (y_o == '0));

    // R5
    disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (en_low_n_i || !en_high_i) |=> (y_o == '0));

    // R2
    live_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!hold_i && !en_low_n_i && en_high_i) |=> (y_o == (OUT_N'(1) << $past(addr_i))));

    // R7
    out_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0(y_o));

endmodule

// File: tb/latdec_top_tb_top.sv
`timescale 1ns/1ps
module latdec_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] addr;
    logic       hold;
    logic       en_low_n;
    logic       en_high;
    logic [7:0] y;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // bench model state
    logic [2:0] m_held;
    logic       m_seen;

    always #2 clk = ~clk;

    latdec_top dut_i (
        .clk_i      (clk),
        .rst_n_i    (rst_n),
        .addr_i     (addr),
        .hold_i     (hold),
        .en_low_n_i (en_low_n),
        .en_high_i  (en_high),
        .y_o        (y)
    );

    function automatic logic [7:0] exp_lines(input logic [2:0] a, input logic el_n, input logic eh);
        return (!el_n && eh) ? (8'd1 << a) : 8'd0;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: y=%b expected %b", req, act, exp);
        end
    endtask

    // Drive one cycle from a negedge, update the model, then check at the next negedge
    task automatic cycle(input logic [2:0] a, input logic h, input logic el_n, input logic eh,
                         input string req);
        logic [2:0] s;
        addr = a; hold = h; en_low_n = el_n; en_high = eh;
        s = (!h || !m_seen) ? a : m_held;
        m_held = s;
        m_seen = h;
        @(posedge clk);
        @(negedge clk);
        check(req, y, exp_lines(s, el_n, eh));
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: y=%b expected completion", y);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; addr = 3'd6; hold = 1'b0; en_low_n = 1'b0; en_high = 1'b1;
        m_held = '0; m_seen = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", y, 8'd0);
        rst_n = 1'b1;

        // R2: every address, pass through, enables active
        for (int a = 0; a < 8; a++) cycle(3'(a), 1'b0, 1'b0, 1'b1, "R2");
        cycle(3'b101, 1'b0, 1'b0, 1'b1, "R2");
        check("R2", y, 8'b0010_0000);

        // R5: each disabling combination, with several addresses and hold levels
        for (int a = 0; a < 8; a++) begin
            cycle(3'(a), 1'b0, 1'b1, 1'b1, "R5");
            cycle(3'(a), 1'b0, 1'b0, 1'b0, "R5");
            cycle(3'(a), 1'b1, 1'b1, 1'b0, "R5");
        end

        // R3/R4: capture at the first held edge, then address changes ignored
        cycle(3'd2, 1'b0, 1'b0, 1'b1, "R8");
        cycle(3'd6, 1'b1, 1'b0, 1'b1, "R3");
        check("R3", y, 8'b0100_0000);
        cycle(3'd1, 1'b1, 1'b0, 1'b1, "R4");
        cycle(3'd7, 1'b1, 1'b0, 1'b1, "R4");
        check("R4", y, 8'b0100_0000);

        // R6: disable while holding, change address, re-enable
        cycle(3'd3, 1'b1, 1'b1, 1'b1, "R5");
        cycle(3'd0, 1'b1, 1'b0, 1'b0, "R5");
        cycle(3'd4, 1'b1, 1'b0, 1'b1, "R6");
        check("R6", y, 8'b0100_0000);

        // R8: release resumes the live address
        cycle(3'd1, 1'b0, 1'b0, 1'b1, "R8");
        check("R8", y, 8'b0000_0010);

        // R3 right after a release: the capture takes the new address, not the old one
        cycle(3'd3, 1'b1, 1'b0, 1'b1, "R3");
        cycle(3'd5, 1'b1, 1'b0, 1'b1, "R4");
        check("R4", y, 8'b0000_1000);

        // Random mix against the model, plus exclusivity
        for (int i = 0; i < 400; i++) begin
            logic [2:0] ra;
            logic rh, rl, re;
            ra = 3'($urandom_range(0, 7));
            rh = ($urandom_range(0, 3) == 0) ? ~hold : hold;
            rl = ($urandom_range(0, 4) == 0);
            re = ($urandom_range(0, 4) != 0);
            cycle(ra, rh, rl, re, "R4");
            checks++;
            if (((!rl && re) && $countones(y) != 1) || $countones(y) > 1) begin
                errors++;
                $display("FAIL R7: y=%b expected one-hot (enabled=%0b)", y, !rl && re);
            end
        end

        // R1 again: reset mid-run while holding clears the held address
        rst_n = 1'b0; hold = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", y, 8'd0);
        rst_n = 1'b1;
        m_held = '0; m_seen = 1'b0;
        cycle(3'd7, 1'b0, 1'b0, 1'b1, "R2");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule